// File: doc/BRIEF.md
# Punctured Serial Convolutional Encoder

This block encodes a bit stream with a rate-1/2 convolutional code and then deletes selected coded bits according to two per-position keep masks. What remains leaves the block one bit per cycle on a single serial output. A group of N accepted input bits yields M surviving coded bits. M is the total number of ones in the two masks, with N < M < 2N, so the effective rate is N/M. Because M serial bits leave for every N bits taken in, the block throttles its source. After the last bit of each group it holds its ready-for-data output low for M−N cycles.

The constraint length K, the two generator codes and the two keep masks are elaboration parameters. The default is K=7 with generators 1111001 and 1011011, N=3, and masks 101 (coded bit 0) and 011 (coded bit 1), which gives M=4. A first-data strobe taken together with an accepted bit realigns the puncture pattern so that this bit becomes the first of a group. Surviving bits are staged in a small queue so that each output block lags its input group by one block. The first block after reset is all zeros.

The control is a two-state machine. In GS_TAKE the block is ready for data. On the edge that accepts the last bit of a group, the machine moves from GS_TAKE to GS_GAP. In GS_GAP the block is not ready. It returns from GS_GAP to GS_TAKE after M−N enabled cycles. A synchronous clear from any state returns it to GS_TAKE.

Top module: `pce_serial_encoder`

## Requirements
- R1: For each accepted bit d, coded bit j is the XOR of the window {d, h} masked by generator j, where h holds the previous K−1 accepted bits with the newest at the top. The generator's MSB taps d. After clear, h is all zeros.
- R2: Bit i of each keep mask (LSB = i = 0) governs the i-th bit of a group. A 1 keeps that coded bit and a 0 deletes it. When both are kept, coded bit 0 is sent before coded bit 1. Without a first-data strobe, the first accepted bit after clear is position 0.
- R3: After the edge that accepts position N−1 of a group, rfd_o is low for exactly M−N cycles and then returns high.
- R4: A strobe on nd_i or fd_i while rfd_o is low is ignored, whatever din_i carries.
- R5: rdy_o rises in the cycle after the edge that accepts the group's last bit. That edge releases the previously held block (after clear, M zeros). The current group's bits wait for the next group end.
- R6: When fd_i and nd_i are both high on an accepting edge, that bit takes position 0. A partly filled group is closed, and its bits are still sent in order.
- R7: rffd_o is high exactly when rfd_o is high and the next accepted bit would take position 0. It is low in the cycle after a valid first-data strobe.
- R8: While ce_i is low, no input is taken and rfd_o, rffd_o, rdy_o and dout_o hold their values.
- R9: clr_i overrides ce_i. During clear nothing is sampled. In the cycle after clear, rdy_o=0, rfd_o=1 and rffd_o=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| ce_i | input | 1 | Clock enable; low freezes the block |
| clr_i | input | 1 | Synchronous clear, active high |
| din_i | input | 1 | Input bit to encode |
| nd_i | input | 1 | New-data strobe for din_i |
| fd_i | input | 1 | First-data strobe; realigns the puncture phase |
| rfd_o | output | 1 | Ready for data |
| rffd_o | output | 1 | Ready for a group's first bit |
| dout_o | output | 1 | Serial punctured output bit |
| rdy_o | output | 1 | dout_o carries a valid bit |

## Verification
The effect of an accepting edge shows in the cycle right after it. On the edge that ends a group, rfd_o drops and rdy_o begins the released block in that next cycle, and rffd_o drops after a valid first-data strobe. The bench drives inputs and samples outputs at the falling edge. It logs a serial bit only in cycles whose coming rising edge is enabled. It measures each low run of rfd_o in enabled cycles and compares it with M−N. It compares the logged serial stream against a queue that holds M zeros followed by every kept bit in order, computed from the generator and mask equations.

// File: rtl/pce_pkg.sv
package pce_pkg;

    typedef enum logic [0:0] {
        GS_TAKE = 1'b0,
        GS_GAP  = 1'b1
    } grp_state_t;

    function automatic int ones_in(input logic [31:0] v);
        int n;
        n = 0;
        for (int i = 0; i < 32; i++) begin
            n += int'(v[i]);
        end
        return n;
    endfunction

endpackage

// File: rtl/pce_tap_encoder.sv
module pce_tap_encoder #(
    parameter int           K  = 7,
    parameter logic [K-1:0] G0 = 7'b1111001,
    parameter logic [K-1:0] G1 = 7'b1011011
) (
    input  logic clk_i,
    input  logic clr_i,
    input  logic take_i,
    input  logic din_i,
    output logic c0_o,
    output logic c1_o
);

    logic [K-2:0] hist_q;
    logic [K-1:0] win;

    always_comb begin
        win  = {din_i, hist_q};
        c0_o = ^(win & G0);
        c1_o = ^(win & G1);
    end

    always_ff @(posedge clk_i) begin
        if (clr_i) begin
            hist_q <= '0;
        end else if (take_i) begin
            hist_q <= win[K-1:1];
        end
    end

    // R1: the window history is empty after a clear
    a_r1_hist_cleared: assert property (@(posedge clk_i) clr_i |=> (hist_q == '0));

    // R1: the newest history bit is the bit just taken
    a_r1_newest_on_top: assert property (@(posedge clk_i) disable iff (clr_i)
        take_i |=> (hist_q[K-2] == $past(din_i)));

endmodule

// File: rtl/pce_group_ctrl.sv
module pce_group_ctrl
    import pce_pkg::*;
#(
    parameter int           N  = 3,
    parameter int           M  = 4,
    parameter logic [N-1:0] P0 = 3'b101,
    parameter logic [N-1:0] P1 = 3'b011
) (
    input  logic       clk_i,
    input  logic       ce_i,
    input  logic       clr_i,
    input  logic       nd_i,
    input  logic       fd_i,
    input  logic       space_ok_i,
    input  logic       c0_i,
    input  logic       c1_i,
    output logic       rfd_o,
    output logic       rffd_o,
    output logic       take_o,
    output logic       close_full_o,
    output logic       close_part_o,
    output logic [1:0] push_n_o,
    output logic       w0_o,
    output logic       w1_o
);

    localparam int GAP = M - N;
    localparam int PW  = $clog2(N);
    localparam int GW  = $clog2(GAP + 1);
    localparam logic [PW-1:0] LAST_PH = PW'(N - 1);

    grp_state_t    st_q, st_d;
    logic [PW-1:0] ph_q, ph_d, eff_ph;
    logic [GW-1:0] gap_q, gap_d;
    logic          fd_take, keep0, keep1;

    // output process
    always_comb begin
        rfd_o        = (st_q == GS_TAKE) && space_ok_i;
        rffd_o       = rfd_o && (ph_q == '0);
        take_o       = ce_i && !clr_i && nd_i && rfd_o;
        fd_take      = take_o && fd_i;
        eff_ph       = fd_take ? '0 : ph_q;
        keep0        = take_o && P0[eff_ph];
        keep1        = take_o && P1[eff_ph];
        push_n_o     = {keep0 && keep1, keep0 ^ keep1};
        w0_o         = keep0 ? c0_i : c1_i;
        w1_o         = c1_i;
        close_part_o = fd_take && (ph_q != '0);
        close_full_o = take_o && (eff_ph == LAST_PH);
    end

    // next-state logic
    always_comb begin
        st_d  = st_q;
        ph_d  = ph_q;
        gap_d = gap_q;
        if (take_o) begin
            ph_d = (eff_ph == LAST_PH) ? '0 : eff_ph + 1'b1;
        end
        unique case (st_q)
            GS_TAKE: begin
                if (close_full_o) begin
                    st_d  = GS_GAP;
                    gap_d = GW'(GAP);
                end
            end
            GS_GAP: begin
                if (ce_i) begin
                    if (gap_q == GW'(1)) begin
                        st_d  = GS_TAKE;
                        gap_d = '0;
                    end else begin
                        gap_d = gap_q - 1'b1;
                    end
                end
            end
            default: st_d = GS_TAKE;
        endcase
    end

    // state register process
    always_ff @(posedge clk_i) begin
        if (clr_i) begin
            st_q  <= GS_TAKE;
            ph_q  <= '0;
            gap_q <= '0;
        end else begin
            st_q  <= st_d;
            ph_q  <= ph_d;
            gap_q <= gap_d;
        end
    end

    a_r3_gap_entry: assert property (@(posedge clk_i) disable iff (clr_i)
        close_full_o |=> (st_q == GS_GAP) && (gap_q == GW'(GAP)));

    a_r3_gap_bound: assert property (@(posedge clk_i) disable iff (clr_i)
        (st_q == GS_GAP) |-> (gap_q != '0) && (gap_q <= GW'(GAP)));

    a_r4_gap_holds_phase: assert property (@(posedge clk_i) disable iff (clr_i)
        !rfd_o |=> $stable(ph_q));

    a_r6_fd_restarts: assert property (@(posedge clk_i) disable iff (clr_i)
        fd_take |=> (ph_q == PW'(1)));

endmodule

// File: rtl/pce_bit_queue.sv
module pce_bit_queue #(
    parameter int M     = 4,
    parameter int DEPTH = 2 * M + 2
) (
    input  logic       clk_i,
    input  logic       ce_i,
    input  logic       clr_i,
    input  logic [1:0] push_n_i,
    input  logic       w0_i,
    input  logic       w1_i,
    input  logic       close_full_i,
    input  logic       close_part_i,
    output logic       dout_o,
    output logic       rdy_o,
    output logic       space_ok_o
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic          mem_q [DEPTH];
    logic [AW-1:0] rd_q, wr_q;
    logic [CW-1:0] occ_q, auth_q, held_q, cur_q;
    logic          pop;

    function automatic logic [AW-1:0] adv(input logic [AW-1:0] p, input logic [1:0] inc);
        int t;
        t = int'(p) + int'(inc);
        if (t >= DEPTH) t -= DEPTH;
        return AW'(t);
    endfunction

    always_comb begin
        rdy_o      = (auth_q != '0);
        dout_o     = mem_q[rd_q];
        space_ok_o = (occ_q <= CW'(DEPTH - 2));
        pop        = ce_i && rdy_o;
    end

    always_ff @(posedge clk_i) begin
        if (clr_i) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= 1'b0;
            rd_q   <= '0;
            wr_q   <= AW'(M);
            occ_q  <= CW'(M);
            auth_q <= '0;
            held_q <= CW'(M);
            cur_q  <= '0;
        end else if (ce_i) begin
            if (push_n_i != 2'd0) mem_q[wr_q] <= w0_i;
            if (push_n_i == 2'd2) mem_q[adv(wr_q, 2'd1)] <= w1_i;
            wr_q  <= adv(wr_q, push_n_i);
            if (pop) rd_q <= adv(rd_q, 2'd1);
            occ_q <= occ_q + CW'(push_n_i) - CW'(pop);
            if (close_part_i) begin
                auth_q <= auth_q - CW'(pop) + held_q;
                held_q <= cur_q;
                cur_q  <= CW'(push_n_i);
            end else if (close_full_i) begin
                auth_q <= auth_q - CW'(pop) + held_q;
                held_q <= cur_q + CW'(push_n_i);
                cur_q  <= '0;
            end else begin
                auth_q <= auth_q - CW'(pop);
                cur_q  <= cur_q + CW'(push_n_i);
            end
        end
    end

    a_r5_occ_bound: assert property (@(posedge clk_i) disable iff (clr_i)
        occ_q <= CW'(DEPTH));

    a_r5_ready_backed: assert property (@(posedge clk_i) disable iff (clr_i)
        rdy_o |-> (auth_q <= occ_q));

    a_r5_accounting: assert property (@(posedge clk_i) disable iff (clr_i)
        occ_q == auth_q + held_q + cur_q);

    a_r8_frozen: assert property (@(posedge clk_i) disable iff (clr_i)
        !ce_i |=> $stable(rd_q) && $stable(occ_q) && $stable(auth_q));

endmodule

// File: rtl/pce_serial_encoder.sv
module pce_serial_encoder
    import pce_pkg::*;
#(
    parameter int           K  = 7,
    parameter logic [K-1:0] G0 = 7'b1111001,
    parameter logic [K-1:0] G1 = 7'b1011011,
    parameter int           N  = 3,
    parameter logic [N-1:0] P0 = 3'b101,
    parameter logic [N-1:0] P1 = 3'b011
) (
    input  logic clk_i,
    input  logic ce_i,
    input  logic clr_i,
    input  logic din_i,
    input  logic nd_i,
    input  logic fd_i,
    output logic rfd_o,
    output logic rffd_o,
    output logic dout_o,
    output logic rdy_o
);

    localparam int M     = ones_in(32'(P0)) + ones_in(32'(P1));
    localparam int DEPTH = 2 * M + 2;

    logic       take, c0, c1, close_full, close_part, space_ok, w0, w1;
    logic [1:0] push_n;

    pce_tap_encoder #(.K(K), .G0(G0), .G1(G1)) u_enc (
        .clk_i (clk_i),
        .clr_i (clr_i),
        .take_i(take),
        .din_i (din_i),
        .c0_o  (c0),
        .c1_o  (c1)
    );

    pce_group_ctrl #(.N(N), .M(M), .P0(P0), .P1(P1)) u_ctrl (
        .clk_i       (clk_i),
        .ce_i        (ce_i),
        .clr_i       (clr_i),
        .nd_i        (nd_i),
        .fd_i        (fd_i),
        .space_ok_i  (space_ok),
        .c0_i        (c0),
        .c1_i        (c1),
        .rfd_o       (rfd_o),
        .rffd_o      (rffd_o),
        .take_o      (take),
        .close_full_o(close_full),
        .close_part_o(close_part),
        .push_n_o    (push_n),
        .w0_o        (w0),
        .w1_o        (w1)
    );

    pce_bit_queue #(.M(M), .DEPTH(DEPTH)) u_queue (
        .clk_i       (clk_i),
        .ce_i        (ce_i),
        .clr_i       (clr_i),
        .push_n_i    (push_n),
        .w0_i        (w0),
        .w1_i        (w1),
        .close_full_i(close_full),
        .close_part_i(close_part),
        .dout_o      (dout_o),
        .rdy_o       (rdy_o),
        .space_ok_o  (space_ok)
    );

    a_r7_fd_drops_rffd: assert property (@(posedge clk_i) disable iff (clr_i)
        (ce_i && nd_i && fd_i && rfd_o) |=> !rffd_o);

    a_r8_outputs_hold: assert property (@(posedge clk_i) disable iff (clr_i)
        !ce_i |=> $stable(rdy_o) && $stable(dout_o) && $stable(rfd_o));

    a_r9_clear_state: assert property (@(posedge clk_i)
        clr_i |=> !rdy_o && rfd_o && rffd_o);

endmodule

// File: tb/pce_serial_encoder_tb.sv
module pce_serial_encoder_tb_top;

    localparam int           CLK_P = 10;
    localparam int           K     = 7;
    localparam logic [K-1:0] G0    = 7'b1111001;
    localparam logic [K-1:0] G1    = 7'b1011011;
    localparam int           N     = 3;
    localparam logic [N-1:0] P0    = 3'b101;
    localparam logic [N-1:0] P1    = 3'b011;
    localparam int           M     = 4;
    localparam int           NSTIM = 6;
    // stimulus word (bits fed LSB first) and expected serial length after drain
    localparam logic [11:0] STIM [NSTIM] = '{12'h000, 12'hFFF, 12'hA5C, 12'h001, 12'h800, 12'h6B3};
    localparam int          EXPN [NSTIM] = '{16, 16, 16, 16, 16, 16};

    logic clk = 1'b0;
    logic ce_i = 1'b1, clr_i = 1'b1, din_i = 1'b0, nd_i = 1'b0, fd_i = 1'b0;
    logic rfd_o, rffd_o, dout_o, rdy_o;

    int   nchk = 0, nfail = 0;
    bit   done = 1'b0;
    logic exp_bits [512];
    logic rcv_bits [512];
    int   exp_len, rcv_len, mph, low_run, acc_cnt, cyc, close_cyc, first_rdy, rffd_err;
    logic [K-2:0] mhist;
    bit   fd_pending, last_acc;

    pce_serial_encoder #(.K(K), .G0(G0), .G1(G1), .N(N), .P0(P0), .P1(P1)) dut_i (
        .clk_i(clk), .ce_i(ce_i), .clr_i(clr_i), .din_i(din_i), .nd_i(nd_i), .fd_i(fd_i),
        .rfd_o(rfd_o), .rffd_o(rffd_o), .dout_o(dout_o), .rdy_o(rdy_o)
    );

    initial forever #(CLK_P / 2) clk = ~clk;

    task automatic check(input bit ok, input string msg, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", msg, act, exp);
        end
    endtask

    task automatic model_reset();
        mhist = '0; mph = 0; low_run = 0; acc_cnt = 0;
        close_cyc = -1; first_rdy = -1; fd_pending = 1'b0;
        for (int j = 0; j < M; j++) exp_bits[j] = 1'b0;
        exp_len = M; rcv_len = 0;
    endtask

    task automatic model_take(input logic d, input logic f);
        logic [K-1:0] w;
        w = {d, mhist};
        if (f) begin mph = 0; fd_pending = 1'b1; end
        if (P0[mph]) begin exp_bits[exp_len] = ^(w & G0); exp_len++; end
        if (P1[mph]) begin exp_bits[exp_len] = ^(w & G1); exp_len++; end
        mhist = w[K-1:1];
        mph = (mph == N - 1) ? 0 : mph + 1;
        acc_cnt++;
        if (acc_cnt == N && close_cyc < 0) close_cyc = cyc;
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic step(input logic nd_v, input logic fd_v, input logic din_v,
                        input logic ce_v, input logic clr_v);
        nd_i = nd_v; fd_i = fd_v; din_i = din_v; ce_i = ce_v; clr_i = clr_v;
        #1;
        last_acc = 1'b0;
        if (!clr_v) begin
            if (fd_pending) begin
                check(rffd_o == 1'b0, "R7 rffd low after valid first-data", int'(rffd_o), 0);
                fd_pending = 1'b0;
            end
            if (rffd_o !== (rfd_o && mph == 0)) rffd_err++;
        end
        if (ce_v && !clr_v) begin
            if (rdy_o) begin
                if (first_rdy < 0) first_rdy = cyc;
                rcv_bits[rcv_len] = dout_o; rcv_len++;
            end
            if (!rfd_o) low_run++;
            else if (low_run != 0) begin
                check(low_run == M - N, "R3 rfd low run length", low_run, M - N);
                low_run = 0;
            end
            if (nd_v && rfd_o) begin
                model_take(din_v, fd_v);
                last_acc = 1'b1;
            end
        end
        @(posedge clk);
        @(negedge clk);
        cyc++;
        if (clr_v) model_reset();
    endtask

    task automatic compare_stream(input string msg);
        int bad, first;
        bad = 0; first = -1;
        for (int j = 0; j < rcv_len; j++) begin
            if (j >= exp_len || rcv_bits[j] !== exp_bits[j]) begin
                bad++;
                if (first < 0) first = j;
            end
        end
        if (first < 0) check(1'b1, msg, 0, 0);
        else check(1'b0, msg, int'(rcv_bits[first]), (first < exp_len) ? int'(exp_bits[first]) : -1);
    endtask

    task automatic feed(input int count, input logic [15:0] bits, input bit gaps);
        int idx, c;
        idx = 0; c = 0;
        while (idx < count) begin
            logic b, nd_v;
            b    = bits[idx];
            nd_v = !(gaps && (c % 4 == 3));
            // during a stall, present the inverted bit and a first-data strobe (R4)
            if (!rfd_o) step(1'b1, 1'b1, ~b, 1'b1, 1'b0);
            else step(nd_v, 1'b0, b, 1'b1, 1'b0);
            if (last_acc) idx++;
            c++;
        end
    endtask

    task automatic drain(input int n);
        for (int j = 0; j < n; j++) step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        cyc = 0; rffd_err = 0;
        model_reset();
        @(negedge clk);
        for (int j = 0; j < 3; j++) step(1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
        // R9: reset state
        check(rdy_o == 1'b0, "R9 rdy after clear", int'(rdy_o), 0);
        check(rfd_o == 1'b1, "R9 rfd after clear", int'(rfd_o), 1);
        check(rffd_o == 1'b1, "R9 rffd after clear", int'(rffd_o), 1);

        // table walk: R1 R2 R4 R5
        for (int e = 0; e < NSTIM; e++) begin
            step(1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
            feed(12, {4'b0, STIM[e]}, e[0]);
            drain(10);
            check(rcv_len == EXPN[e], "R5 released block count", rcv_len, EXPN[e]);
            check(first_rdy == close_cyc + 1, "R5 rdy rises after group end", first_rdy, close_cyc + 1);
            compare_stream("R1 R2 R4 serial stream");
        end

        // R6: realignment mid-group
        step(1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
        step(1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
        step(1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
        feed(9, 16'h0135, 1'b0);
        drain(12);
        check(rcv_len == 14, "R6 partial group released", rcv_len, 14);
        compare_stream("R6 stream after realignment");

        // R8: clock enable low freezes the block
        step(1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
        feed(5, 16'h0016, 1'b0);
        begin
            logic r0, d0, f0;
            int   moved;
            r0 = rdy_o; d0 = dout_o; f0 = rfd_o; moved = 0;
            for (int j = 0; j < 6; j++) begin
                step(1'b1, 1'b1, j[0], 1'b0, 1'b0);
                if (rdy_o !== r0 || dout_o !== d0 || rfd_o !== f0) moved++;
            end
            check(moved == 0, "R8 outputs held while disabled", moved, 0);
        end
        feed(7, 16'h004B, 1'b0);
        drain(10);
        compare_stream("R8 stream after disabled cycles");

        // R9: clear overrides a low enable mid-stream
        feed(4, 16'h0009, 1'b0);
        step(1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
        check(rdy_o == 1'b0, "R9 rdy after clear with ce low", int'(rdy_o), 0);
        check(rfd_o == 1'b1 && rffd_o == 1'b1, "R9 ready flags after clear", int'({rfd_o, rffd_o}), 3);
        feed(6, 16'h0027, 1'b0);
        drain(10);
        check(rcv_len == 2 * M, "R9 blocks after clear", rcv_len, 2 * M);
        compare_stream("R9 stream after clear");

        check(rffd_err == 0, "R7 rffd tracks group position", rffd_err, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule